// File: doc/BRIEF.md
# Smart Card Slot Activation Sequencer

This block brings up a smart card slot from a cold host supply to a running card, following the ISO 7816-3 power-up order. While the host supply is valid it counts a fixed settling interval, and it refuses activation until that interval has elapsed. The host then requests activation with a falling edge on an active-low command line. The card must be present, the supply must be free of faults and host reset must be low at that moment.

On an accepted command the sequencer enables card VCC and starts one timer. At the first checkpoint it samples the VCC-good flag, and it aborts if VCC has not come up. At the second checkpoint it releases the I/O line into reception mode. At the third it starts the card clock. From then on the card reset output follows host reset.

Removing the card, a supply fault or a loss of supply at any point after the command shuts every output off at once. Each of these drives the active-low fault output low. A rising edge on the command line while the card is running shuts the card down in reverse order: reset first, then clock, then I/O, then VCC. Each of these steps lasts a programmable number of cycles.

Top module: `card_activation_seq`

## Requirements
- R1: While rst_n is low, and in the first cycle after reset, vcc_en, io_en, clk_en and card_rst are 0 and fault_n is 1.
- R2: A command falling edge is ignored until supply_ok has been sampled high on LOCK_CYC consecutive clock edges. A low supply_ok restarts this count.
- R3: Activation starts only on a 1-to-0 transition of cmd_n between two clock edges. At that edge card_in must be 1, vdd_fault 0 and host_rst 0. A cmd_n held low, or an edge that fails these conditions, has no effect.
- R4: vcc_en goes to 1 in the cycle after the clock edge that accepted the command (t0).
- R5: vcc_good is sampled at the edge T1_CYC cycles after t0. If it is 0, vcc_en returns to 0 and fault_n goes to 0 at that edge, and the block returns to idle.
- R6: io_en goes to 1 at the edge T2_CYC cycles after t0.
- R7: clk_en goes to 1 at the edge T3_CYC cycles after t0.
- R8: card_rst is 0 until clk_en is 1. After that it equals host_rst combinationally while the card is running.
- R9: Once the command has been accepted and until the block is idle again, card_in = 0, vdd_fault = 1 or supply_ok = 0 at a clock edge clears all four card outputs and drives fault_n to 0 at that edge.
- R10: A 0-to-1 transition of cmd_n while the card is running starts the shutdown. card_rst drops at once. clk_en drops DEACT_CYC cycles later, io_en another DEACT_CYC cycles after that, and vcc_en another DEACT_CYC cycles after that.
- R11: fault_n stays 0 until a later command is accepted. At that edge it returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Host supply above its fault threshold |
| vdd_fault | input | 1 | Host supply fault flag |
| card_in | input | 1 | Card present in the slot |
| vcc_good | input | 1 | Card VCC has reached its level |
| cmd_n | input | 1 | Active-low activation command, edge sensitive |
| host_rst | input | 1 | Host card-reset request |
| vcc_en | output | 1 | Enable for the card VCC regulator |
| io_en | output | 1 | Card I/O released into reception mode |
| clk_en | output | 1 | Card clock running |
| card_rst | output | 1 | Card reset line |
| fault_n | output | 1 | Active-low fault report |

## Verification
The bench builds the block with LOCK_CYC=20, T1_CYC=5, T2_CYC=8, T3_CYC=12 and DEACT_CYC=3. At these values the lockout, every activation checkpoint and every shutdown step fall within tens of cycles. A single run can therefore send a command inside the lockout, fail the VCC check, pull the card during the ramp and while running, and carry out a full ordered shutdown. A behavioural timeline model predicts every output on every cycle.

// File: rtl/card_activation_seq.sv
module card_activation_seq #(
  parameter int LOCK_CYC  = 1000000,
  parameter int T1_CYC    = 2000,
  parameter int T2_CYC    = 2500,
  parameter int T3_CYC    = 3000,
  parameter int DEACT_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic vdd_fault,
  input  logic card_in,
  input  logic vcc_good,
  input  logic cmd_n,
  input  logic host_rst,
  output logic vcc_en,
  output logic io_en,
  output logic clk_en,
  output logic card_rst,
  output logic fault_n
);
  localparam int TMAX = (T3_CYC > DEACT_CYC) ? T3_CYC : DEACT_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int LW   = $clog2(LOCK_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RAMP, S_IOW, S_CLKW, S_RUN, S_DRST, S_DCLK, S_DIO
  } st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [LW-1:0] lcnt;
  logic          cmd_q;
  logic          flt_q;

  wire ready    = (lcnt == LW'(LOCK_CYC));
  wire cmd_fall = cmd_q & ~cmd_n;
  wire cmd_rise = ~cmd_q & cmd_n;
  wire abort    = (st != S_IDLE) & (~card_in | vdd_fault | ~supply_ok);
  wire start    = cmd_fall & ready & card_in & ~vdd_fault & ~host_rst;
  wire step_end = (tmr == TW'(DEACT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcnt  <= '0;
      cmd_q <= 1'b1;
    end else begin
      cmd_q <= cmd_n;
      if (!supply_ok) lcnt <= '0;
      else if (!ready) lcnt <= lcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      tmr   <= '0;
      flt_q <= 1'b1;
    end else if (abort) begin
      st    <= S_IDLE;
      tmr   <= '0;
      flt_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st    <= S_RAMP;
          tmr   <= '0;
          flt_q <= 1'b1;
        end
        S_RAMP: begin
          if (tmr == TW'(T1_CYC - 1) && !vcc_good) begin
            st    <= S_IDLE;
            tmr   <= '0;
            flt_q <= 1'b0;
          end else begin
            tmr <= tmr + 1'b1;
            if (tmr == TW'(T1_CYC - 1)) st <= S_IOW;
          end
        end
        S_IOW: begin
          tmr <= tmr + 1'b1;
          if (tmr == TW'(T2_CYC - 1)) st <= S_CLKW;
        end
        S_CLKW: begin
          tmr <= tmr + 1'b1;
          if (tmr == TW'(T3_CYC - 1)) begin
            st  <= S_RUN;
            tmr <= '0;
          end
        end
        S_RUN: if (cmd_rise) begin
          st  <= S_DRST;
          tmr <= '0;
        end
        S_DRST, S_DCLK, S_DIO: begin
          tmr <= step_end ? '0 : tmr + 1'b1;
          if (step_end) st <= (st == S_DRST) ? S_DCLK : (st == S_DCLK) ? S_DIO : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign vcc_en   = (st != S_IDLE);
  assign io_en    = (st == S_CLKW) | (st == S_RUN) | (st == S_DRST) | (st == S_DCLK);
  assign clk_en   = (st == S_RUN) | (st == S_DRST);
  assign card_rst = (st == S_RUN) & host_rst;
  assign fault_n  = flt_q;
endmodule

module card_activation_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic vdd_fault,
  input logic card_in,
  input logic vcc_good,
  input logic cmd_n,
  input logic host_rst,
  input logic vcc_en,
  input logic io_en,
  input logic clk_en,
  input logic card_rst,
  input logic fault_n
);
  AST_IO_NEEDS_VCC: assert property (@(posedge clk) disable iff (!rst_n) io_en |-> vcc_en); // R6
  AST_CLK_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n) clk_en |-> io_en); // R7
  AST_RST_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n) card_rst |-> clk_en); // R8
  AST_VCC_ON_CMD_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(vcc_en) |-> $past(!cmd_n && card_in && !host_rst)); // R3
  AST_ABORT_CARD_OUT: assert property (@(posedge clk) disable iff (!rst_n) (vcc_en && !card_in) |=> (!vcc_en && !fault_n)); // R9
  AST_FAULT_VCC_OFF: assert property (@(posedge clk) disable iff (!rst_n) $fell(fault_n) |-> !vcc_en); // R5
endmodule

bind card_activation_seq card_activation_seq_chk chk (.*);

// File: tb/card_activation_seq_test.sv
`timescale 1ns/1ps
module card_activation_seq_test;
  localparam int LOCK = 20, T1 = 5, T2 = 8, T3 = 12, D = 3;

  logic clk = 0, rst_n = 0;
  logic supply_ok = 0, vdd_fault = 0, card_in = 0, vcc_good = 0, cmd_n = 1, host_rst = 0;
  logic vcc_en, io_en, clk_en, card_rst, fault_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  card_activation_seq #(.LOCK_CYC(LOCK), .T1_CYC(T1), .T2_CYC(T2), .T3_CYC(T3), .DEACT_CYC(D)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .vdd_fault(vdd_fault), .card_in(card_in),
    .vcc_good(vcc_good), .cmd_n(cmd_n), .host_rst(host_rst), .vcc_en(vcc_en), .io_en(io_en),
    .clk_en(clk_en), .card_rst(card_rst), .fault_n(fault_n));

  int mode = 0, el = 0, scnt = 0, pcmd = 1;
  bit e_fault = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 0; el = 0; scnt = 0; pcmd = 1; e_fault = 1;
    end else begin
      bit fall, rise, rdy;
      fall = (pcmd == 1) && !cmd_n;
      rise = (pcmd == 0) && cmd_n;
      rdy  = (scnt == LOCK);
      if (mode != 0 && (!card_in || vdd_fault || !supply_ok)) begin
        mode = 0; e_fault = 0;
      end else begin
        case (mode)
          0: if (fall && rdy && card_in && !vdd_fault && !host_rst) begin mode = 1; el = 0; e_fault = 1; end
          1: if (el == T1 - 1 && !vcc_good) begin mode = 0; e_fault = 0; end
             else begin el++; if (el == T3) mode = 2; end
          2: if (rise) begin mode = 3; el = 0; end
          3: begin el++; if (el == 3 * D) mode = 0; end
          default: mode = 0;
        endcase
      end
      scnt = !supply_ok ? 0 : (scnt < LOCK ? scnt + 1 : scnt);
      pcmd = cmd_n;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R4 vcc_en",   vcc_en,   mode != 0);
    chk("R6 io_en",    io_en,    (mode == 1 && el >= T2) || mode == 2 || (mode == 3 && el < 2 * D));
    chk("R7 clk_en",   clk_en,   mode == 2 || (mode == 3 && el < D));
    chk("R8 card_rst", card_rst, mode == 2 && host_rst);
    chk("R5 fault_n",  fault_n,  e_fault);
  end

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic pulse_cmd();
    cmd_n = 0; tick(1);
  endtask

  initial begin
    tick(3);
    chk("R1 vcc_en reset", vcc_en, 0);
    chk("R1 fault_n reset", fault_n, 1);
    rst_n = 1; tick(1);
    chk("R1 io_en after reset", io_en, 0);
    supply_ok = 1; card_in = 1; vcc_good = 1; tick(5);
    pulse_cmd(); tick(3);
    chk("R2 lockout ignores cmd", vcc_en, 0);
    cmd_n = 1; tick(LOCK + 2);
    pulse_cmd(); cmd_n = 0; tick(1); cmd_n = 1; tick(1);
    tick(1);
    cmd_n = 1; tick(2);
    card_in = 0; cmd_n = 0; tick(2);
    chk("R3 no card ignored", vcc_en, 0);
    cmd_n = 1; card_in = 1; host_rst = 1; tick(1); cmd_n = 0; tick(2);
    chk("R3 host_rst high ignored", vcc_en, 0);
    cmd_n = 1; host_rst = 0; tick(2);
    card_in = 0; tick(1);
    chk("R2 vcc_en idle", vcc_en, 0);
    card_in = 1; tick(1);
    cmd_n = 0; tick(1);
    chk("R4 vcc on after edge", vcc_en, 1);
    tick(T3 + 2);
    chk("R7 clock running", clk_en, 1);
    host_rst = 1; tick(1);
    chk("R8 rst follows", card_rst, 1);
    host_rst = 0; #1;
    chk("R8 rst low", card_rst, 0);
    host_rst = 1; tick(2);
    cmd_n = 1; tick(1);
    chk("R10 rst drops first", card_rst, 0);
    chk("R10 clk still on", clk_en, 1);
    tick(D);
    chk("R10 clk off", clk_en, 0);
    chk("R10 io still on", io_en, 1);
    tick(2 * D);
    chk("R10 vcc off", vcc_en, 0);
    host_rst = 0; vcc_good = 0; tick(1);
    cmd_n = 0; tick(T1 + 1);
    chk("R5 fault on bad vcc", fault_n, 0);
    chk("R5 vcc off", vcc_en, 0);
    cmd_n = 1; vcc_good = 1; tick(2);
    cmd_n = 0; tick(1);
    chk("R11 fault cleared", fault_n, 1);
    tick(3); card_in = 0; tick(1);
    chk("R9 abort ramp", vcc_en, 0);
    chk("R9 abort fault", fault_n, 0);
    card_in = 1; cmd_n = 1; tick(2);
    cmd_n = 0; tick(T3 + 3);
    vdd_fault = 1; tick(1);
    chk("R9 vdd fault clk off", clk_en, 0);
    chk("R9 vdd fault", fault_n, 0);
    vdd_fault = 0; tick(5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule